// File: doc/BRIEF.md
# External Interrupt Sense Controller

The block turns a small set of external interrupt pins into per-pin interrupt requests. Each pin has its own 2-bit sense field. The field selects one of four detection modes: low level, falling edge, rising edge, or either edge. Every pin input first passes through a synchronizer chain. An edge is found by comparing the synchronized value with the value it had one cycle earlier.

In level mode the request output follows the inverted synchronized pin and is not stored. In the edge modes a detected edge sets a sticky per-pin flag, and that flag drives the request. Software clears the flag by writing 1 to its bit in a status register. Software reaches the block over a plain register bus with an address, a write strobe, write data and combinational read data. The block does no priority resolution and no vectoring; a downstream controller consumes the request lines.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the control register reads 0, all flags are 0, every pin uses low-level detection, and with all pins high no request is driven.
- R2: The control register sits at address 0. The sense field of pin i occupies bits 2i+1:2i. Bits 15:8 always read as 0 and writes to them have no effect.
- R3: Sense code 00 makes the request of that pin equal to the inverse of the pin after two synchronizer flops. The request is not latched, and no flag is ever set in this mode.
- R4: Sense code 01 sets the pin's flag on a high-to-low change of the synchronized pin. While the flag is set, the request output is high.
- R5: Sense code 10 sets the pin's flag on a low-to-high change of the synchronized pin.
- R6: Sense code 11 sets the pin's flag on a change of the synchronized pin in either direction.
- R7: The status register sits at address 1, with bit i holding the flag of pin i. Writing 1 to a bit clears that flag. Writing 0 leaves it unchanged. A flag otherwise stays set.
- R8: When an edge is detected in the same cycle as a clearing write for that pin, the flag stays set.
- R9: A control write that changes a pin's sense field clears that pin's flag. A write that keeps the same value leaves the flag alone.
- R10: Addresses other than 0 and 1 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_pin_i | input | NUM_PINS | External interrupt pins, asynchronous |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wr_i | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the current address, combinational |
| irq_req_o | output | NUM_PINS | Per-pin interrupt request |

## Verification
The assertions assume that the bus inputs change only between clock edges. They also assume the pins enter through the synchronizer, so the checker reasons only about the synchronized value and its delayed copy, never about the raw pin. The stimulus follows both assumptions: it drives every input, pins included, one nanosecond after a rising edge and holds it for the whole cycle. Reset is applied with all pins high, which matches the synchronizer's reset value, so no edge appears when reset is released. The clearing writes are swept across several offsets from a pin change, so that one of them coincides with a detected edge.

// File: rtl/eis_pkg.sv
package eis_pkg;

   localparam int SENSE_W = 2;

   typedef enum logic [SENSE_W-1:0] {
      SENSE_LOW  = 2'b00,
      SENSE_FALL = 2'b01,
      SENSE_RISE = 2'b10,
      SENSE_BOTH = 2'b11
   } sense_e;

endpackage

// File: rtl/eis_sync.sv
module eis_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   initial begin
      if (STAGES < 2) $error("eis_sync: STAGES must be at least 2");
   end

   generate
      if (STAGES == 2) begin : g_two
         logic meta_q, stab_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               meta_q <= RST_VAL;
               stab_q <= RST_VAL;
            end else begin
               meta_q <= d_i;
               stab_q <= meta_q;
            end
         end
         assign q_o = stab_q;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/eis_detect.sv
module eis_detect
   import eis_pkg::*;
#(
   parameter logic RST_VAL = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   sync_i,
   input  sense_e sense_i,
   input  logic   mode_chg_i,
   input  logic   clr_i,
   output logic   prev_o,
   output logic   flag_o,
   output logic   irq_o
);

   logic prev_q;
   logic flag_q;
   logic hit;

   always_comb begin
      unique case (sense_i)
         SENSE_LOW:  hit = 1'b0;
         SENSE_FALL: hit = prev_q & ~sync_i;
         SENSE_RISE: hit = ~prev_q & sync_i;
         SENSE_BOTH: hit = prev_q ^ sync_i;
         default:    hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= RST_VAL;
         flag_q <= 1'b0;
      end else begin
         prev_q <= sync_i;
         if (mode_chg_i)  flag_q <= 1'b0;
         else if (hit)    flag_q <= 1'b1;
         else if (clr_i)  flag_q <= 1'b0;
      end
   end

   assign prev_o = prev_q;
   assign flag_o = flag_q;
   assign irq_o  = (sense_i == SENSE_LOW) ? ~sync_i : flag_q;

endmodule

// File: rtl/eis_regs.sv
module eis_regs
   import eis_pkg::*;
#(
   parameter int NUM_PINS  = 4,
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 16,
   parameter int CTRL_ADDR = 0,
   parameter int STAT_ADDR = 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           addr_i,
   input  logic                        wr_i,
   input  logic [DATA_W-1:0]           wdata_i,
   input  logic [NUM_PINS-1:0]         flags_i,
   output logic [NUM_PINS*SENSE_W-1:0] ctrl_o,
   output logic [NUM_PINS-1:0]         mode_chg_o,
   output logic [NUM_PINS-1:0]         clr_o,
   output logic [DATA_W-1:0]           rdata_o
);

   localparam int                CTRL_W = NUM_PINS * SENSE_W;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   logic [CTRL_W-1:0] ctrl_q;
   logic              wr_ctrl;
   logic              wr_stat;

   assign wr_ctrl = wr_i && (addr_i == A_CTRL);
   assign wr_stat = wr_i && (addr_i == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
   end

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         assign mode_chg_o[i] = wr_ctrl &&
                                (wdata_i[i*SENSE_W +: SENSE_W] != ctrl_q[i*SENSE_W +: SENSE_W]);
         assign clr_o[i]      = wr_stat && wdata_i[i];
      end
      if (CTRL_W < DATA_W) begin : g_hi
         logic unused_hi;
         assign unused_hi = ^wdata_i[DATA_W-1:CTRL_W];
      end
   endgenerate

   always_comb begin
      rdata_o = '0;
      if (addr_i == A_CTRL)      rdata_o[CTRL_W-1:0]   = ctrl_q;
      else if (addr_i == A_STAT) rdata_o[NUM_PINS-1:0] = flags_i;
   end

   assign ctrl_o = ctrl_q;

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
   import eis_pkg::*;
#(
   parameter int   NUM_PINS    = 4,
   parameter int   ADDR_W      = 2,
   parameter int   DATA_W      = 16,
   parameter int   SYNC_STAGES = 2,
   parameter int   CTRL_ADDR   = 0,
   parameter int   STAT_ADDR   = 1,
   parameter logic PIN_IDLE    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] irq_pin_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic                bus_wr_i,
   input  logic [DATA_W-1:0]   bus_wdata_i,
   output logic [DATA_W-1:0]   bus_rdata_o,
   output logic [NUM_PINS-1:0] irq_req_o
);

   localparam int CTRL_W = NUM_PINS * SENSE_W;

   initial begin
      if (NUM_PINS < 1)             $error("ext_irq_sense: NUM_PINS must be positive");
      if (CTRL_W > DATA_W)          $error("ext_irq_sense: sense fields exceed DATA_W");
      if (SYNC_STAGES < 2)          $error("ext_irq_sense: SYNC_STAGES must be at least 2");
      if (CTRL_ADDR == STAT_ADDR)   $error("ext_irq_sense: register addresses overlap");
      if (CTRL_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W))
         $error("ext_irq_sense: register address out of range");
   end

   logic [CTRL_W-1:0]   mode_q;
   logic [NUM_PINS-1:0] sync_q;
   logic [NUM_PINS-1:0] prev_q;
   logic [NUM_PINS-1:0] flag_q;
   logic [NUM_PINS-1:0] mode_chg;
   logic [NUM_PINS-1:0] clr;

   eis_regs #(
      .NUM_PINS  (NUM_PINS),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .CTRL_ADDR (CTRL_ADDR),
      .STAT_ADDR (STAT_ADDR)
   ) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr_i     (bus_addr_i),
      .wr_i       (bus_wr_i),
      .wdata_i    (bus_wdata_i),
      .flags_i    (flag_q),
      .ctrl_o     (mode_q),
      .mode_chg_o (mode_chg),
      .clr_o      (clr),
      .rdata_o    (bus_rdata_o)
   );

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         eis_sync #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (PIN_IDLE)
         ) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (irq_pin_i[i]),
            .q_o   (sync_q[i])
         );

         eis_detect #(
            .RST_VAL (PIN_IDLE)
         ) det_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_i     (sync_q[i]),
            .sense_i    (sense_e'(mode_q[i*SENSE_W +: SENSE_W])),
            .mode_chg_i (mode_chg[i]),
            .clr_i      (clr[i]),
            .prev_o     (prev_q[i]),
            .flag_o     (flag_q[i]),
            .irq_o      (irq_req_o[i])
         );
      end
   endgenerate

endmodule

// File: rtl/eis_checker.sv
module eis_checker #(
   parameter int NUM_PINS  = 4,
   parameter int ADDR_W    = 2,
   parameter int DATA_W    = 16,
   parameter int CTRL_ADDR = 0,
   parameter int STAT_ADDR = 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [ADDR_W-1:0]     bus_addr_i,
   input logic                  bus_wr_i,
   input logic [DATA_W-1:0]     bus_wdata_i,
   input logic [DATA_W-1:0]     bus_rdata_o,
   input logic [2*NUM_PINS-1:0] mode_q,
   input logic [NUM_PINS-1:0]   sync_q,
   input logic [NUM_PINS-1:0]   prev_q,
   input logic [NUM_PINS-1:0]   flag_q
);

   localparam int                CTRL_W = 2 * NUM_PINS;
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   generate
      if (CTRL_W < DATA_W) begin : g_rsvd
         AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_addr_i == A_CTRL) |-> (bus_rdata_o[DATA_W-1:CTRL_W] == '0)); // R2
      end
   endgenerate

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr_i != A_CTRL && bus_addr_i != A_STAT) |-> (bus_rdata_o == '0)); // R10

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         logic [1:0] md;
         logic       chg;
         logic       wclr;
         assign md   = mode_q[2*i +: 2];
         assign chg  = bus_wr_i && (bus_addr_i == A_CTRL) && (bus_wdata_i[2*i +: 2] != md);
         assign wclr = bus_wr_i && (bus_addr_i == A_STAT) && bus_wdata_i[i];

         AST_LEVEL_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
            (md == 2'b00) |-> !flag_q[i]); // R3
         AST_FALL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (md == 2'b01 && prev_q[i] && !sync_q[i] && !chg) |=> flag_q[i]); // R4
         AST_RISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (md == 2'b10 && !prev_q[i] && sync_q[i] && !chg) |=> flag_q[i]); // R5
         AST_BOTH_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (md == 2'b11 && (prev_q[i] != sync_q[i]) && !chg) |=> flag_q[i]); // R6
         AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (md != 2'b00 && wclr && !chg && (prev_q[i] != sync_q[i]) &&
             (md == 2'b11 || sync_q[i] == md[1])) |=> flag_q[i]); // R8
         AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !wclr && !chg) |=> flag_q[i]); // R7
         AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            chg |=> !flag_q[i]); // R9
      end
   endgenerate

endmodule

bind ext_irq_sense eis_checker #(
   .NUM_PINS  (NUM_PINS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CTRL_ADDR (CTRL_ADDR),
   .STAT_ADDR (STAT_ADDR)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr_i  (bus_addr_i),
   .bus_wr_i    (bus_wr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_rdata_o (bus_rdata_o),
   .mode_q      (mode_q),
   .sync_q      (sync_q),
   .prev_q      (prev_q),
   .flag_q      (flag_q)
);

// File: tb/ext_irq_sense_tb_top.sv
module ext_irq_sense_tb_top;

   localparam int N = 4;

   logic          clk   = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins  = '1;
   logic [1:0]    addr  = '0;
   logic          wr    = 1'b0;
   logic [15:0]   wdata = '0;
   logic [15:0]   rdata;
   logic [N-1:0]  irq;

   always #2 clk = ~clk;

   ext_irq_sense dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_pin_i   (pins),
      .bus_addr_i  (addr),
      .bus_wr_i    (wr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_req_o   (irq)
   );

   // behavioural reference state
   bit        m_s1[N], m_s2[N], m_pv[N], m_fl[N];
   bit [7:0]  m_mode;
   int        errors = 0;
   int        checks = 0;
   string     req    = "R1";
   bit        done   = 0;

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            m_s1[i] = 1; m_s2[i] = 1; m_pv[i] = 1; m_fl[i] = 0;
         end
         m_mode = '0;
      end else begin
         for (int i = 0; i < N; i++) begin
            int md;
            bit hit, chg, clr;
            md  = (m_mode >> (2 * i)) & 3;
            hit = (md == 1 && m_pv[i] && !m_s2[i]) ||
                  (md == 2 && !m_pv[i] && m_s2[i]) ||
                  (md == 3 && m_pv[i] != m_s2[i]);
            chg = wr && addr == 0 && (((wdata >> (2 * i)) & 3) != md);
            clr = wr && addr == 1 && wdata[i];
            if (chg)      m_fl[i] = 0;
            else if (hit) m_fl[i] = 1;
            else if (clr) m_fl[i] = 0;
            m_pv[i] = m_s2[i];
            m_s2[i] = m_s1[i];
            m_s1[i] = pins[i];
         end
         if (wr && addr == 0) m_mode = wdata[7:0];
      end
   endtask

   task automatic compare();
      logic [15:0] e_irq, e_rd;
      e_irq = '0;
      e_rd  = '0;
      for (int i = 0; i < N; i++) begin
         int md;
         md = (m_mode >> (2 * i)) & 3;
         e_irq[i] = (md == 0) ? !m_s2[i] : m_fl[i];
      end
      if (addr == 0)      e_rd = {8'h00, m_mode};
      else if (addr == 1) for (int i = 0; i < N; i++) e_rd[i] = m_fl[i];
      check({req, " irq"}, {12'h000, irq}, e_irq);
      check({req, " rdata"}, rdata, e_rd);
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      model_edge();
      compare();
   endtask

   task automatic idle(int n);
      wr = 0;
      for (int k = 0; k < n; k++) step();
   endtask

   task automatic bus_write(logic [1:0] a, logic [15:0] d);
      addr = a; wdata = d; wr = 1;
      step();
      wr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      req = "R1";
      for (int k = 0; k < 3; k++) step();
      rst_n = 1;
      idle(3);
      check("R1 ctrl", rdata, 16'h0000);
      check("R1 irq", {12'h000, irq}, 16'h0000);

      // R3: level mode follows pin, not latched
      req = "R3";
      pins[0] = 0; idle(2);
      pins[0] = 1; idle(1);
      check("R3 level released", {15'h0, irq[0]}, 16'h0001);
      idle(2);
      check("R3 level not latched", {15'h0, irq[0]}, 16'h0000);
      pins[1] = 0; pins[3] = 0; idle(5);
      pins[1] = 1; pins[3] = 1; idle(4);

      // R2: control register, reserved bits ignored; pin3=11 pin2=10 pin1=01 pin0=00
      req = "R2";
      bus_write(2'd0, 16'hABE4);
      idle(1);
      check("R2 readback", rdata, 16'h00E4);

      // R4: falling edge on pin1
      req = "R4";
      pins[1] = 0; idle(5);
      check("R4 fall flag", {15'h0, irq[1]}, 16'h0001);
      pins[1] = 1; idle(4);
      check("R4 sticky", {15'h0, irq[1]}, 16'h0001);

      // R5: rising edge on pin2
      req = "R5";
      pins[2] = 0; idle(4);
      check("R5 no flag on fall", {15'h0, irq[2]}, 16'h0000);
      pins[2] = 1; idle(4);
      check("R5 rise flag", {15'h0, irq[2]}, 16'h0001);

      // R6: both edges on pin3
      req = "R6";
      pins[3] = 0; idle(4);
      check("R6 fall", {15'h0, irq[3]}, 16'h0001);

      // R7: clear via status register
      req = "R7";
      addr = 2'd1; idle(1);
      check("R7 status", rdata, 16'h000E);
      bus_write(2'd1, 16'h0000);
      addr = 2'd1; idle(1);
      check("R7 zero write", rdata, 16'h000E);
      bus_write(2'd1, 16'h0008);
      addr = 2'd1; idle(1);
      check("R7 clear pin3", rdata, 16'h0006);
      req = "R6";
      pins[3] = 1; idle(4);
      check("R6 rise", {15'h0, irq[3]}, 16'h0001);
      req = "R7";
      bus_write(2'd1, 16'h000F);
      addr = 2'd1; idle(1);
      check("R7 clear all", rdata, 16'h0000);

      // R8: clear swept against an edge on pin3 (both-edge mode)
      req = "R8";
      for (int off = 0; off < 5; off++) begin
         pins[3] = ~pins[3];
         idle(off);
         bus_write(2'd1, 16'h0008);
         addr = 2'd1;
         idle(4);
      end
      pins[3] = ~pins[3]; idle(2);
      bus_write(2'd1, 16'h0008);
      addr = 2'd1; idle(1);
      check("R8 edge beats clear", rdata, 16'h0008);
      bus_write(2'd1, 16'h000F);
      if (pins[3] == 0) begin pins[3] = 1; idle(4); bus_write(2'd1, 16'h000F); end

      // R9: mode change clears, same value keeps
      req = "R9";
      pins[1] = 0; idle(4); pins[1] = 1; idle(3);
      addr = 2'd1; idle(1);
      check("R9 flag set", rdata, 16'h0002);
      bus_write(2'd0, 16'h00E4);
      addr = 2'd1; idle(1);
      check("R9 same value keeps", rdata, 16'h0002);
      bus_write(2'd0, 16'h00EC);
      addr = 2'd1; idle(1);
      check("R9 change clears", rdata, 16'h0000);

      // R10: unmapped addresses
      req = "R10";
      bus_write(2'd2, 16'hFFFF);
      bus_write(2'd3, 16'hFFFF);
      addr = 2'd2; idle(1);
      check("R10 addr2", rdata, 16'h0000);
      addr = 2'd3; idle(1);
      check("R10 addr3", rdata, 16'h0000);
      addr = 2'd0; idle(1);
      check("R10 ctrl untouched", rdata, 16'h00EC);

      // mixed traffic on all pins with random-looking pattern
      req = "R6";
      for (int k = 0; k < 40; k++) begin
         pins = N'((k * 7 + 3) >> (k % 3));
         addr = 2'(k % 4);
         idle(2);
         if (k % 5 == 0) bus_write(2'd1, 16'(k));
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule